// File: doc/BRIEF.md
# Serial Module Stop and Freeze Sequencer

This block sits beside a serial peripheral module made of two engines: a queued SPI engine and an asynchronous serial interface (SCI). It decides when the module may enter its low-power stopped state, and whether a debug freeze input pauses the SPI engine. Register writes arrive on two strobed groups. The control group carries the stop request and the freeze-enable bit. The halt group carries the SPI halt request. The SPI engine reports each transfer boundary, and the SCI reports its receiver and transmitter enables.

Stop entry follows an ordered handshake. Software first requests a halt. The block acknowledges that halt at the next transfer boundary. Only after that acknowledge, and only while both SCI directions are disabled, is a stop request taken. A stop request that breaks this order is dropped and raises a sticky protocol-error flag. The module clock enable follows the stopped state one cycle late. The block leaves reset in the stopped state, and all writes keep working while it is stopped.

Top module: `sermod_pwr_ctl`

## Requirements
- R1: After reset, `stopped`=1, `clk_en`=0, and `halt_req`, `halt_ack`, `frz_halt` and `proto_err` are all 0.
- R2: When `stopped`=0, a control write with `ctl_stop`=1 is refused if any bit of `sci_en` is 1 (bit 0 receiver, bit 1 transmitter). `stopped` stays 0 and `proto_err` is 1 after that edge.
- R3: When `stopped`=0, a control write with `ctl_stop`=1 is refused if `halt_ack` is 0. `stopped` stays 0 and `proto_err` is 1 after that edge.
- R4: When `halt_ack`=1 and `sci_en`=0, a control write with `ctl_stop`=1 sets `stopped` at that edge.
- R5: `halt_ack` rises on the edge that ends a cycle in which `halt_req`=1 and `spi_boundary`=1. It falls on the edge of a halt write with `hlt_val`=0. `halt_req` takes `hlt_val` at each halt write.
- R6: With the freeze enable set, `frz_halt` rises on the edge that ends a cycle in which `freeze_in`=1 and `spi_boundary`=1. It holds until `freeze_in` is sampled 0, and then falls at that edge.
- R7: With the freeze enable cleared, `freeze_in` has no effect, and `frz_halt` is 0 one cycle later.
- R8: `clk_en` equals the inverse of `stopped` as it was one cycle earlier.
- R9: While `stopped`=1, halt writes and freeze-enable writes take effect, and a control write with `ctl_stop`=0 clears `stopped`.
- R10: When a stop write and a halt write with `hlt_val`=0 land in the same cycle, the stop decision uses the acknowledge held before that edge. The stop is taken, and `halt_ack` clears at the same edge.
- R11: `proto_err` stays set until a control write with `ctl_stop`=0 clears it. A stop write while already stopped changes neither `stopped` nor `proto_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control-group write strobe |
| ctl_stop | input | 1 | Stop request bit of a control write |
| ctl_frz_en | input | 1 | Freeze-enable bit of a control write |
| hlt_we | input | 1 | Halt-group write strobe |
| hlt_val | input | 1 | Halt request bit of a halt write |
| freeze_in | input | 1 | Debug freeze input |
| sci_en | input | SCI_EN_W | SCI direction enables (bit 0 receiver, bit 1 transmitter) |
| spi_boundary | input | 1 | SPI engine is at a transfer boundary this cycle |
| halt_req | output | 1 | Halt request to the SPI engine |
| halt_ack | output | 1 | Halt acknowledged at a boundary |
| frz_halt | output | 1 | Freeze-caused halt command to the SPI engine |
| clk_en | output | 1 | Module clock-gate enable |
| stopped | output | 1 | Module is in the stopped state |
| proto_err | output | 1 | Sticky flag for a refused stop write |

## Verification
The stop decision and the halt acknowledge update can fall in the same cycle. This happens when software writes the stop bit and clears the halt in one cycle. The bench drives both strobes together after the acknowledge is up. It expects `stopped` set and `halt_ack` cleared after that single edge, because the decision must use the acknowledge value from before the edge. A second overlap places a boundary pulse in the same cycle as the freeze input. The bench also checks that a freeze with the enable cleared leaves `frz_halt` low.

// File: rtl/sermod_pkg.sv
package sermod_pkg;

  // a stop may be taken only once the halt is acknowledged and the SCI is idle
  function automatic logic stop_permitted(input logic ack, input logic sci_busy);
    return ack && !sci_busy;
  endfunction

  // next acknowledge: cleared by a halt write of 0, set by a boundary while halted
  function automatic logic ack_next(input logic ack, input logic halt, input logic bnd,
                                    input logic clr);
    if (clr) return 1'b0;
    return halt && (ack || bnd);
  endfunction

endpackage

// File: rtl/sermod_cfg_regs.sv
module sermod_cfg_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_we,
  input  logic ctl_frz_en,
  input  logic hlt_we,
  input  logic hlt_val,
  output logic halt_q,
  output logic frz_en_q,
  output logic halt_clr
);
  assign halt_clr = hlt_we && !hlt_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q   <= 1'b0;
      frz_en_q <= 1'b0;
    end else begin
      if (hlt_we) halt_q <= hlt_val;
      if (ctl_we) frz_en_q <= ctl_frz_en;
    end
  end
endmodule

// File: rtl/sermod_halt_track.sv
module sermod_halt_track (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_q,
  input  logic halt_clr,
  input  logic frz_en_q,
  input  logic freeze_in,
  input  logic spi_boundary,
  output logic ack_q,
  output logic frz_halt_q
);
  import sermod_pkg::*;

  logic frz_active;
  assign frz_active = frz_en_q && freeze_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q      <= 1'b0;
      frz_halt_q <= 1'b0;
    end else begin
      ack_q      <= ack_next(ack_q, halt_q, spi_boundary, halt_clr);
      frz_halt_q <= frz_active && (frz_halt_q || spi_boundary);
    end
  end

  // R5
  ack_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(halt_q && spi_boundary));

  // R6
  frz_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frz_halt_q) |-> $past(frz_en_q && freeze_in && spi_boundary));

  // R7
  frz_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frz_en_q |=> !frz_halt_q);
endmodule

// File: rtl/sermod_stop_gate.sv
module sermod_stop_gate #(
  parameter int SCI_EN_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_we,
  input  logic                ctl_stop,
  input  logic                ack_q,
  input  logic [SCI_EN_W-1:0] sci_en,
  output logic                stop_q,
  output logic                err_q,
  output logic                clk_en_q
);
  import sermod_pkg::*;

  logic sci_busy, permit, stop_try, stop_take, stop_refuse, stop_clear;
  assign sci_busy    = |sci_en;
  assign permit      = stop_permitted(ack_q, sci_busy);
  assign stop_try    = ctl_we && ctl_stop && !stop_q;
  assign stop_take   = stop_try && permit;
  assign stop_refuse = stop_try && !permit;
  assign stop_clear  = ctl_we && !ctl_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q   <= 1'b1;
      err_q    <= 1'b0;
      clk_en_q <= 1'b0;
    end else begin
      clk_en_q <= !stop_q;
      if (stop_clear) begin
        stop_q <= 1'b0;
        err_q  <= 1'b0;
      end else if (stop_take) begin
        stop_q <= 1'b1;
      end else if (stop_refuse) begin
        err_q  <= 1'b1;
      end
    end
  end

  // R2 R3 R4
  stop_ordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_q) |-> $past(ack_q && (sci_en == '0)));

  // R11
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(ctl_we && ctl_stop && !stop_q));

  // R8
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_q) |=> !clk_en_q);

  // R8
  gate_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_q) |=> clk_en_q);
endmodule

// File: rtl/sermod_pwr_ctl.sv
module sermod_pwr_ctl #(
  parameter int SCI_EN_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_we,
  input  logic                ctl_stop,
  input  logic                ctl_frz_en,
  input  logic                hlt_we,
  input  logic                hlt_val,
  input  logic                freeze_in,
  input  logic [SCI_EN_W-1:0] sci_en,
  input  logic                spi_boundary,
  output logic                halt_req,
  output logic                halt_ack,
  output logic                frz_halt,
  output logic                clk_en,
  output logic                stopped,
  output logic                proto_err
);
  logic halt_q, frz_en_q, halt_clr, ack_q, frz_halt_q;
  logic stop_q, err_q, clk_en_q;

  sermod_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_frz_en(ctl_frz_en),
    .hlt_we(hlt_we), .hlt_val(hlt_val), .halt_q(halt_q), .frz_en_q(frz_en_q),
    .halt_clr(halt_clr)
  );

  sermod_halt_track u_trk (
    .clk(clk), .rst_n(rst_n), .halt_q(halt_q), .halt_clr(halt_clr),
    .frz_en_q(frz_en_q), .freeze_in(freeze_in), .spi_boundary(spi_boundary),
    .ack_q(ack_q), .frz_halt_q(frz_halt_q)
  );

  sermod_stop_gate #(.SCI_EN_W(SCI_EN_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_stop(ctl_stop),
    .ack_q(ack_q), .sci_en(sci_en), .stop_q(stop_q), .err_q(err_q),
    .clk_en_q(clk_en_q)
  );

  assign halt_req  = halt_q;
  assign halt_ack  = ack_q;
  assign frz_halt  = frz_halt_q;
  assign clk_en    = clk_en_q;
  assign stopped   = stop_q;
  assign proto_err = err_q;

  // R10
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_stop && !stopped && halt_ack && sci_en == '0 && hlt_we && !hlt_val)
      |=> (stopped && !halt_ack));
endmodule

// File: tb/sermod_pwr_ctl_test.sv
module sermod_pwr_ctl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0, ctl_stop = 0, ctl_frz_en = 0, hlt_we = 0, hlt_val = 0;
  logic freeze_in = 0, spi_boundary = 0;
  logic [1:0] sci_en = 2'b00;
  logic halt_req, halt_ack, frz_halt, clk_en, stopped, proto_err;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { string tag; logic [5:0] exp; } item_t;
  item_t sb[$];

  // model state
  bit m_halt = 0, m_ack = 0, m_frzen = 0, m_fh = 0, m_clk = 0, m_stop = 1, m_err = 0;

  sermod_pwr_ctl uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_stop(ctl_stop),
    .ctl_frz_en(ctl_frz_en), .hlt_we(hlt_we), .hlt_val(hlt_val),
    .freeze_in(freeze_in), .sci_en(sci_en), .spi_boundary(spi_boundary),
    .halt_req(halt_req), .halt_ack(halt_ack), .frz_halt(frz_halt),
    .clk_en(clk_en), .stopped(stopped), .proto_err(proto_err)
  );

  always #10 clk = ~clk;

  function automatic logic [5:0] model_vec();
    return {m_halt, m_ack, m_fh, m_clk, m_stop, m_err};
  endfunction

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [5:0] act;
      it  = sb.pop_front();
      act = {halt_req, halt_ack, frz_halt, clk_en, stopped, proto_err};
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%b expected=%b (halt_req,halt_ack,frz_halt,clk_en,stopped,proto_err)",
                 it.tag, act, it.exp);
      end
    end
  end

  // driver: apply one cycle of stimulus, advance the model, queue expectation
  task automatic cyc(input string tag, input bit cw, input bit cs, input bit cf,
                     input bit hw, input bit hv, input bit fz, input bit [1:0] sci,
                     input bit bnd);
    bit n_stop, n_err, n_ack, n_fh;
    ctl_we = cw; ctl_stop = cs; ctl_frz_en = cf; hlt_we = hw; hlt_val = hv;
    freeze_in = fz; sci_en = sci; spi_boundary = bnd;
    @(posedge clk);
    #1;
    n_stop = m_stop; n_err = m_err;
    if (cw) begin
      if (!cs) begin n_stop = 0; n_err = 0; end
      else if (!m_stop) begin
        if (m_ack && sci == 2'b00) n_stop = 1; else n_err = 1;
      end
    end
    if (hw && !hv) n_ack = 0;
    else n_ack = m_halt && (m_ack || bnd);
    n_fh  = (m_frzen && fz) ? (m_fh || bnd) : 1'b0;
    m_clk = !m_stop;
    m_stop = n_stop; m_err = n_err; m_ack = n_ack; m_fh = n_fh;
    if (hw) m_halt = hv;
    if (cw) m_frzen = cf;
    sb.push_back('{tag, model_vec()});
    @(negedge clk);
    ctl_we = 0; hlt_we = 0; spi_boundary = 0;
  endtask

  task automatic idle(input string tag, input bit fz, input bit [1:0] sci);
    cyc(tag, 0, 0, m_frzen, 0, 0, fz, sci, 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sb.push_back('{"R1 reset state", model_vec()});
    @(negedge clk);
    idle("R1 stopped out of reset", 0, 0);

    // leave stop, clock gate follows one cycle later
    cyc("R9 clear stop", 1, 0, 0, 0, 0, 0, 0, 0);
    idle("R8 clk_en back", 0, 0);

    // stop without acknowledge
    cyc("R3 stop without ack refused", 1, 1, 0, 0, 0, 0, 0, 0);
    idle("R11 err sticky", 0, 0);
    cyc("R11 err cleared by stop=0 write", 1, 0, 0, 0, 0, 0, 0, 0);

    // halt handshake
    cyc("R5 halt write", 0, 0, 0, 1, 1, 0, 0, 0);
    idle("R5 no boundary no ack", 0, 0);
    cyc("R5 boundary", 0, 0, 0, 0, 0, 0, 0, 1);
    idle("R5 ack held", 0, 0);

    // SCI busy blocks stop
    cyc("R2 stop with receiver on", 1, 1, 0, 0, 0, 0, 2'b01, 0);
    cyc("R11 clear err", 1, 0, 0, 0, 0, 0, 2'b10, 0);
    cyc("R2 stop with transmitter on", 1, 1, 0, 0, 0, 0, 2'b10, 0);
    cyc("R11 clear err again", 1, 0, 0, 0, 0, 0, 0, 0);

    // collision: stop plus halt clear in one cycle
    cyc("R10 stop and halt clear together", 1, 1, 0, 1, 0, 0, 0, 0);
    idle("R8 clk_en drops", 0, 0);
    cyc("R11 stop write while stopped", 1, 1, 0, 0, 0, 0, 0, 0);

    // writes while stopped
    cyc("R9 halt write while stopped", 0, 0, 0, 1, 1, 0, 0, 0);
    cyc("R9 freeze enable write while stopped", 1, 1, 1, 0, 0, 0, 0, 0);
    cyc("R9 ack while stopped", 0, 0, 1, 0, 0, 0, 0, 1);
    cyc("R4 clear stop", 1, 0, 1, 0, 0, 0, 0, 0);
    idle("R8 clk_en up", 0, 0);
    cyc("R4 ordered stop taken", 1, 1, 1, 0, 0, 0, 0, 0);
    cyc("R4 leave stop", 1, 0, 1, 0, 0, 0, 0, 0);

    // freeze behaviour
    idle("R6 freeze no boundary", 1, 0);
    cyc("R6 freeze with boundary", 0, 0, 1, 0, 0, 1, 0, 1);
    idle("R6 freeze held", 1, 0);
    idle("R6 freeze released", 0, 0);
    cyc("R7 disable freeze", 1, 0, 0, 0, 0, 1, 0, 0);
    cyc("R7 freeze ignored at boundary", 0, 0, 0, 0, 0, 1, 0, 1);
    idle("R7 still ignored", 1, 0);
    cyc("R5 halt clear", 0, 0, 0, 1, 0, 0, 0, 0);
    idle("R5 ack gone", 0, 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule